// File: doc/BRIEF.md
# Vector Even-Element Carry-Less Multiply-Long Unit

This block takes two vector operands of a fixed, compile-time length and divides each into wide lanes. In every wide lane it reads only the lower half, which is the even-indexed narrow element. It multiplies the two narrow elements as polynomials over GF(2), with no carries, and writes the double-width product into that wide lane of the result. The product of two n-bit polynomials has at most 2n-1 significant bits, so the top bit of every lane is always zero. There is no predication: every lane is written.

A 2-bit size code chooses the lane width at run time. Code `01` gives 16-bit lanes, code `11` gives 64-bit lanes, and code `00` gives 128-bit lanes. The 128-bit setting is allowed only while the wide-enable input is high. Code `10`, and code `00` without wide-enable, are illegal. An illegal request gives no valid result. It raises the illegal flag for one cycle and drives the result to zero.

The unit has one registered stage with valid/ready handshakes on both sides. A surrounding pipeline uses it as one execution slot.

Top module: `vclm_mull_even`

## Requirements
- R1: Each product is carry-less: partial products `b << i`, one for every set bit `i` of `a`, are combined with XOR.
- R2: Size code `01` gives 16-bit lanes. Lane e is the product of operand bits `[16e+7:16e]` of each input.
- R3: Size code `11` gives 64-bit lanes. Lane e is the product of operand bits `[64e+31:64e]` of each input.
- R4: Size code `00` with `wide_en`=1 gives 128-bit lanes. Lane e is the product of operand bits `[128e+63:128e]` of each input.
- R5: Size code `00` with `wide_en`=0 is illegal. The unit then asserts `out_illegal` for exactly one cycle, keeps `out_valid` low and drives `out_result` to zero.
- R6: Size code `10` is illegal whatever the value of `wide_en`, with the same output behaviour as R5.
- R7: The upper (odd-indexed) half of each wide lane of either operand has no effect on the result.
- R8: Every lane of a legal result is written, and the most significant bit of every lane is zero.
- R9: An input accepted on a clock edge (`in_valid` and `in_ready` both high) shows up at that same edge as `out_valid` (legal request) or as `out_illegal` (illegal request).
- R10: While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` hold and `in_ready` is low. When `out_valid` is low, `in_ready` is high.
- R11: After reset, `out_valid` and `out_illegal` are 0, `out_result` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_a | input | VLEN | First vector operand |
| in_b | input | VLEN | Second vector operand |
| in_size | input | 2 | Lane size code |
| wide_en | input | 1 | Allows the 128-bit lane setting |
| out_valid | output | 1 | Legal result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | VLEN | Packed lane products |
| out_illegal | output | 1 | One-cycle flag for an illegal request |

## Verification
Every result is due at the clock edge that accepts its request. The bench drives inputs on the falling edge, lets one rising edge pass, and samples `out_valid`, `out_illegal` and `out_result` on the next falling edge. For the backpressure case, the bench holds `out_ready` low across further falling edges and checks that the first result is still present. It then releases `out_ready` and expects the queued request's result one rising edge later.

// File: rtl/vclm_pkg.sv
package vclm_pkg;

   typedef enum logic [1:0] {
      SZ_Q128 = 2'b00,
      SZ_H16  = 2'b01,
      SZ_RSV  = 2'b10,
      SZ_D64  = 2'b11
   } vclm_size_e;

   typedef enum logic [1:0] {
      LSEL_16   = 2'd0,
      LSEL_64   = 2'd1,
      LSEL_128  = 2'd2,
      LSEL_NONE = 2'd3
   } vclm_lsel_e;

   localparam int unsigned NUM_CFG = 3;

   function automatic int unsigned cfg_lane_w(input int unsigned k);
      case (k)
         0:       return 16;
         1:       return 64;
         default: return 128;
      endcase
   endfunction

endpackage

// File: rtl/vclm_decode.sv
module vclm_decode
   import vclm_pkg::*;
(
   input  logic [1:0]  size_code,
   input  logic        wide_en,
   output vclm_lsel_e  lane_sel,
   output logic        illegal
);

   always_comb begin
      lane_sel = LSEL_NONE;
      illegal  = 1'b1;
      case (vclm_size_e'(size_code))
         SZ_H16: begin
            lane_sel = LSEL_16;
            illegal  = 1'b0;
         end
         SZ_D64: begin
            lane_sel = LSEL_64;
            illegal  = 1'b0;
         end
         SZ_Q128: begin
            if (wide_en) begin
               lane_sel = LSEL_128;
               illegal  = 1'b0;
            end
         end
         default: begin
            lane_sel = LSEL_NONE;
            illegal  = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/vclm_lane_clmul.sv
module vclm_lane_clmul #(
   parameter int unsigned SRC_W = 8,
   localparam int unsigned PROD_W = 2 * SRC_W
) (
   input  logic [SRC_W-1:0]  op_a,
   input  logic [SRC_W-1:0]  op_b,
   output logic [PROD_W-1:0] prod
);

   if (SRC_W < 1) begin : g_bad_w
      $error("vclm_lane_clmul: SRC_W must be at least 1");
   end

   logic [PROD_W-1:0] b_ext;
   assign b_ext = {{SRC_W{1'b0}}, op_b};

   always_comb begin
      prod = '0;
      for (int unsigned i = 0; i < SRC_W; i++) begin
         if (op_a[i]) prod = prod ^ (b_ext << i);
      end
   end

endmodule

// File: rtl/vclm_lane_array.sv
module vclm_lane_array #(
   parameter int unsigned VLEN   = 256,
   parameter int unsigned LANE_W = 16,
   localparam int unsigned HALF_W = LANE_W / 2,
   localparam int unsigned NLANES = VLEN / LANE_W
) (
   input  logic [VLEN-1:0] vec_a,
   input  logic [VLEN-1:0] vec_b,
   output logic [VLEN-1:0] vec_p
);

   if (LANE_W < 2 || (LANE_W % 2) != 0) begin : g_bad_lane
      $error("vclm_lane_array: LANE_W must be even and at least 2");
   end
   if ((VLEN % LANE_W) != 0) begin : g_bad_vlen
      $error("vclm_lane_array: VLEN must be a multiple of LANE_W");
   end

   for (genvar e = 0; e < NLANES; e++) begin : g_lane
      vclm_lane_clmul #(.SRC_W(HALF_W)) u_mul (
         .op_a (vec_a[e*LANE_W +: HALF_W]),
         .op_b (vec_b[e*LANE_W +: HALF_W]),
         .prod (vec_p[e*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/vclm_out_stage.sv
module vclm_out_stage #(
   parameter int unsigned VLEN = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [VLEN-1:0] in_data,
   input  logic            in_illegal,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [VLEN-1:0] out_data,
   output logic            out_illegal
);

   logic            full_q;
   logic            ill_q;
   logic [VLEN-1:0] data_q;
   logic            slot_free;
   logic            take;

   assign slot_free = !full_q || ill_q || out_ready;
   assign take      = in_valid && slot_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         ill_q  <= 1'b0;
         data_q <= '0;
      end else if (take) begin
         full_q <= 1'b1;
         ill_q  <= in_illegal;
         data_q <= in_illegal ? '0 : in_data;
      end else if (slot_free) begin
         full_q <= 1'b0;
         ill_q  <= 1'b0;
      end
   end

   assign in_ready    = slot_free;
   assign out_valid   = full_q && !ill_q;
   assign out_illegal = full_q && ill_q;
   assign out_data    = data_q;

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid != out_illegal));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_ready_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   p_illegal_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (!out_valid && out_data == '0));

   p_illegal_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_illegal && !in_valid) |=> !out_illegal);

endmodule

// File: rtl/vclm_mull_even.sv
module vclm_mull_even
   import vclm_pkg::*;
#(
   parameter int unsigned VLEN = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [VLEN-1:0] in_a,
   input  logic [VLEN-1:0] in_b,
   input  logic [1:0]      in_size,
   input  logic            wide_en,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [VLEN-1:0] out_result,
   output logic            out_illegal
);

   if (VLEN < 128 || (VLEN % 128) != 0) begin : g_bad_vlen
      $error("vclm_mull_even: VLEN must be a nonzero multiple of 128");
   end

   vclm_lsel_e                   lane_sel;
   logic                         dec_illegal;
   logic [NUM_CFG-1:0][VLEN-1:0] cfg_prod;
   logic [VLEN-1:0]              sel_prod;

   vclm_decode u_dec (
      .size_code (in_size),
      .wide_en   (wide_en),
      .lane_sel  (lane_sel),
      .illegal   (dec_illegal)
   );

   for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
      localparam int unsigned LW = cfg_lane_w(k);
      vclm_lane_array #(.VLEN(VLEN), .LANE_W(LW)) u_arr (
         .vec_a (in_a),
         .vec_b (in_b),
         .vec_p (cfg_prod[k])
      );
   end

   always_comb begin
      case (lane_sel)
         LSEL_16:  sel_prod = cfg_prod[0];
         LSEL_64:  sel_prod = cfg_prod[1];
         LSEL_128: sel_prod = cfg_prod[2];
         default:  sel_prod = '0;
      endcase
   end

   vclm_out_stage #(.VLEN(VLEN)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_data     (sel_prod),
      .in_illegal  (dec_illegal),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .out_data    (out_result),
      .out_illegal (out_illegal)
   );

   p_rsv_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_size == 2'b10) |=> (out_illegal && !out_valid));

   p_wide_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_size == 2'b00 && !wide_en) |=> out_illegal);

   p_top_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_size == 2'b01) |=> !out_result[15]);

endmodule

// File: tb/vclm_mull_even_bench.sv
module vclm_mull_even_bench;

   localparam int unsigned VLEN = 256;
   localparam time CLK_PERIOD = 10ns;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [VLEN-1:0] in_a = '0;
   logic [VLEN-1:0] in_b = '0;
   logic [1:0]      in_size = 2'b01;
   logic            wide_en = 1'b0;
   logic            out_valid;
   logic            out_ready = 1'b1;
   logic [VLEN-1:0] out_result;
   logic            out_illegal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vclm_mull_even #(.VLEN(VLEN)) u_vclm_mull_even (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .in_size(in_size), .wide_en(wide_en),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_result(out_result), .out_illegal(out_illegal)
   );

   function automatic int lane_width(input logic [1:0] sz, input logic wen);
      case (sz)
         2'b01:   return 16;
         2'b11:   return 64;
         2'b00:   return wen ? 128 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic logic [VLEN-1:0] ref_result(input logic [VLEN-1:0] a,
         input logic [VLEN-1:0] b, input logic [1:0] sz, input logic wen);
      logic [VLEN-1:0] r;
      int lw;
      r  = '0;
      lw = lane_width(sz, wen);
      if (lw == 0) return r;
      for (int e = 0; e < VLEN / lw; e++) begin
         logic [63:0]  xa;
         logic [127:0] xb;
         logic [127:0] p;
         xa = '0; xb = '0; p = '0;
         for (int i = 0; i < lw / 2; i++) begin
            xa[i] = a[e*lw + i];
            xb[i] = b[e*lw + i];
         end
         for (int i = 0; i < lw / 2; i++) begin
            if (xa[i]) p = p ^ (xb << i);
         end
         for (int j = 0; j < lw; j++) r[e*lw + j] = p[j];
      end
      return r;
   endfunction

   function automatic logic [VLEN-1:0] rand_vec();
      logic [VLEN-1:0] v;
      for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic check_bit(input string req, input string what,
         input logic act, input logic expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, expv);
      end
   endtask

   task automatic check_vec(input string req, input logic [VLEN-1:0] act,
         input logic [VLEN-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s result: actual %h expected %h", req, act, expv);
      end
   endtask

   // Issue one request with out_ready high; sample on the falling edge after the accepting edge.
   task automatic run_op(input string req, input logic [VLEN-1:0] a,
         input logic [VLEN-1:0] b, input logic [1:0] sz, input logic wen);
      logic legal;
      legal = (lane_width(sz, wen) != 0);
      @(negedge clk);
      in_a = a; in_b = b; in_size = sz; wide_en = wen; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_bit(req, "out_valid", out_valid, legal);
      check_bit(req, "out_illegal", out_illegal, !legal);
      check_vec(req, out_result, ref_result(a, b, sz, wen));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [VLEN-1:0] a0, b0, a1, b1, mask, held;
      void'($urandom(32'h5eed_c1a0));
      repeat (3) @(negedge clk);
      // R11: reset state
      check_bit("R11", "out_valid", out_valid, 1'b0);
      check_bit("R11", "out_illegal", out_illegal, 1'b0);
      check_bit("R11", "in_ready", in_ready, 1'b1);
      check_vec("R11", out_result, '0);
      rst_n = 1'b1;

      // R1: directed carry-less corners, (x+1)*(x+1) = x^2+1 in 16-bit lanes
      run_op("R1", {(VLEN/16){16'h0003}}, {(VLEN/16){16'h0003}}, 2'b01, 1'b0);
      checks++;
      if (out_result[15:0] !== 16'h0005) begin
         errors++;
         $display("FAIL R1 lane0: actual %h expected %h", out_result[15:0], 16'h0005);
      end
      // R8: all ones gives MSB zero in every lane
      run_op("R8", '1, '1, 2'b01, 1'b0);
      check_bit("R8", "lane msb", out_result[VLEN-1], 1'b0);
      run_op("R8", '1, '1, 2'b11, 1'b0);
      run_op("R8", '1, '1, 2'b00, 1'b1);
      check_bit("R8", "wide msb", out_result[127], 1'b0);
      // zero and single-bit operands
      run_op("R2", '0, rand_vec(), 2'b01, 1'b0);
      run_op("R3", {(VLEN/64){64'h0000_0000_8000_0000}}, {(VLEN/64){64'h0000_0000_8000_0000}}, 2'b11, 1'b0);
      run_op("R4", {(VLEN/128){128'h8000_0000_0000_0000}}, {(VLEN/128){128'h8000_0000_0000_0001}}, 2'b00, 1'b1);

      // R5 / R6: illegal encodings
      run_op("R5", rand_vec(), rand_vec(), 2'b00, 1'b0);
      @(negedge clk);
      check_bit("R5", "illegal one cycle", out_illegal, 1'b0);
      run_op("R6", rand_vec(), rand_vec(), 2'b10, 1'b0);
      run_op("R6", rand_vec(), rand_vec(), 2'b10, 1'b1);

      // R7: odd halves ignored
      for (int sz = 0; sz < 3; sz++) begin
         logic [1:0] code;
         int lw;
         code = (sz == 0) ? 2'b01 : (sz == 1) ? 2'b11 : 2'b00;
         lw   = lane_width(code, 1'b1);
         mask = '0;
         for (int e = 0; e < VLEN / lw; e++)
            for (int j = lw / 2; j < lw; j++) mask[e*lw + j] = 1'b1;
         a0 = rand_vec(); b0 = rand_vec();
         run_op("R7", a0, b0, code, 1'b1);
         held = out_result;
         run_op("R7", a0 ^ (rand_vec() & mask), b0 ^ (rand_vec() & mask), code, 1'b1);
         check_vec("R7", out_result, held);
      end

      // R2 R3 R4 R1: random over legal sizes
      for (int n = 0; n < 60; n++) begin
         case (n % 3)
            0:       run_op("R2", rand_vec(), rand_vec(), 2'b01, 1'b0);
            1:       run_op("R3", rand_vec(), rand_vec(), 2'b11, n[0]);
            default: run_op("R4", rand_vec(), rand_vec(), 2'b00, 1'b1);
         endcase
      end

      // R9 / R10: backpressure
      a0 = rand_vec(); b0 = rand_vec(); a1 = rand_vec(); b1 = rand_vec();
      @(negedge clk);
      out_ready = 1'b0;
      in_a = a0; in_b = b0; in_size = 2'b11; wide_en = 1'b0; in_valid = 1'b1;
      @(negedge clk);
      check_bit("R9", "out_valid", out_valid, 1'b1);
      check_bit("R10", "in_ready stalled", in_ready, 1'b0);
      in_a = a1; in_b = b1; in_size = 2'b01;
      repeat (2) @(negedge clk);
      check_bit("R10", "out_valid held", out_valid, 1'b1);
      check_vec("R10", out_result, ref_result(a0, b0, 2'b11, 1'b0));
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_bit("R10", "queued valid", out_valid, 1'b1);
      check_vec("R10", out_result, ref_result(a1, b1, 2'b01, 1'b0));
      @(negedge clk);
      check_bit("R10", "drained", out_valid, 1'b0);
      check_bit("R10", "ready when empty", in_ready, 1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule